// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Controller

This block drives a small group of output pins, by default four, all in lockstep. Each update is triggered by an edge on one of several timer timeout lines. Software chooses the timer line, whether the line is active low, and which edge counts as an event: none, rising, falling or both. Software also writes a pattern word and a per-pin update mask. On every event each unmasked pin is either forced to its pattern bit or, in toggle mode, inverted wherever the pattern bit is 1.

The controller is meant to be re-armed between events. If a second event arrives before software has written the control register again, the block latches an overrun flag and issues a one-cycle interrupt pulse and a one-cycle DMA request pulse together. Software reads the flag back and clears it by writing 0 to it. Access is through a minimal word-wide register port with two locations. Select 0 is the control/status word. Select 1 is a fixed identification word.

Top module: `evt_pattern_out`

## Requirements
- R1: After reset the control word reads 0x00000000, the pins are 0 and the interrupt and DMA outputs are low.
- R2: The control word layout is: enable at bit 0, source select at bits 4:1, edge code at bits 6:5, mode at bit 7, pattern at bits 11:8, mask at bits 15:12, overrun at bit 16, active-low flag at bit 17, live pin state at bits 21:18, and zeros at bits 31:22. Writes to bits 31:18 have no effect.
- R3: Select 1 always reads 0x44D00101. Writes to select 1 change neither location.
- R4: Source select 0 takes timer line 0 and select 1 takes timer line 1. Any other select value produces no events.
- R5: Edge code 00 gives no events, 01 gives rising edges, 10 gives falling edges and 11 gives both edges of the conditioned source.
- R6: With the active-low flag set to 1, the selected line is inverted before edge detection.
- R7: A pin whose mask bit is 0 keeps its value on an event.
- R8: With mode 0 (direct), an event sets each unmasked pin to its pattern bit.
- R9: With mode 1 (toggle), an event inverts each unmasked pin whose pattern bit is 1 and leaves the others unchanged.
- R10: An event with no control write since the previous event sets the overrun bit. In the same cycle it raises the interrupt and DMA outputs, each for one cycle only.
- R11: Writing 0 to the overrun bit clears it. Writing 1 to it leaves it as it was.
- R12: While enable is 0, timer edges change nothing, and no event stays pending for after enable is set again.
- R13: A timer line change applied just after a clock edge becomes visible on the pins on the third rising edge, and not before.
- R14: A control write in the same cycle as an event takes effect first: the event uses the new pattern and no overrun is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_i | input | NSRC (2) | Asynchronous timer timeout lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control/status, 1 identification |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_sel_i |
| pins_o | output | NPINS (4) | Pattern output pins |
| irq_o | output | 1 | Overrun interrupt pulse |
| dma_sync_o | output | 1 | DMA synchronization pulse, coincident with irq_o |

## Verification
Between a change on a timer line and the resulting update of the pins, the overrun flag and the two pulses, there are three registers: two synchronizer stages and the output flops. The bench therefore changes the timer line just after a falling edge and samples on the third falling edge that follows. The latency check also samples one edge earlier, where the pins must still hold their old value. Register writes take effect at the next rising edge. Reads are combinational and are sampled a short delay after a falling edge. The same-cycle test places the write so that it lands on the same rising edge as the event.

// File: rtl/evt_pattern_pkg.sv
package evt_pattern_pkg;

  typedef enum logic [1:0] {
    DET_NONE = 2'b00,
    DET_RISE = 2'b01,
    DET_FALL = 2'b10,
    DET_BOTH = 2'b11
  } det_mode_e;

  localparam logic [1:0]  ID_SCHEME = 2'd1;
  localparam logic [11:0] ID_FUNC   = 12'h4D0;
  localparam logic [2:0]  ID_MAJOR  = 3'd1;
  localparam logic [5:0]  ID_MINOR  = 6'd1;
  localparam logic [31:0] ID_WORD   = {ID_SCHEME, 2'b00, ID_FUNC, 5'd0, ID_MAJOR, 2'd0, ID_MINOR};

  // event decision from previous and current conditioned level
  function automatic logic edge_hit(det_mode_e m, logic prv, logic cur);
    logic rise, fall;
    rise = ~prv & cur;
    fall = prv & ~cur;
    case (m)
      DET_RISE: return rise;
      DET_FALL: return fall;
      DET_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evt_trigger.sv
module evt_trigger
  import evt_pattern_pkg::*;
#(
  parameter int NSRC        = 2,
  parameter int SELW        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tmr_raw,
  input  logic [SELW-1:0] src_sel,
  input  logic            invert,
  input  logic [1:0]      det,
  output logic            hit
);
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] stg [SYNC_STAGES];
  logic            src_ok_w;
  logic            lvl_w;
  logic            cond_w;
  logic            prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= tmr_raw;
      for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign src_ok_w = (src_sel < SELW'(NSRC));
  assign lvl_w    = src_ok_w ? stg[SYNC_STAGES-1][src_sel[IDXW-1:0]] : 1'b0;
  assign cond_w   = lvl_w ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond_w;
  end

  assign hit = src_ok_w & edge_hit(det_mode_e'(det), prev_q, cond_w);

endmodule

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs #(
  parameter int NPINS = 4,
  parameter int SELW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  input  logic             hit,
  input  logic [NPINS-1:0] pins,
  output logic             fire,
  output logic [SELW-1:0]  src_sel,
  output logic [1:0]       det,
  output logic             invert,
  output logic             mode_e,
  output logic [NPINS-1:0] mask_e,
  output logic [NPINS-1:0] pat_e,
  output logic             irq,
  output logic             dma,
  output logic [31:0]      ctrl_rd
);
  localparam int F_EN      = 0;
  localparam int F_SEL_LSB = 1;
  localparam int F_DET_LSB = F_SEL_LSB + SELW;
  localparam int F_MODE    = F_DET_LSB + 2;
  localparam int F_PAT_LSB = F_MODE + 1;
  localparam int F_MSK_LSB = F_PAT_LSB + NPINS;
  localparam int F_OVR     = F_MSK_LSB + NPINS;
  localparam int F_POL     = F_OVR + 1;
  localparam int F_ST_LSB  = F_POL + 1;

  logic             en_q, mode_q, pol_q, ovr_q, fresh_q, irq_q, dma_q;
  logic [SELW-1:0]  sel_q;
  logic [1:0]       det_q;
  logic [NPINS-1:0] pat_q, mask_q;
  logic             en_e, fresh_e, over_w;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[31:F_POL+1];

  // a write in the event cycle is seen first
  assign en_e    = wr_en ? wdata[F_EN]   : en_q;
  assign mode_e  = wr_en ? wdata[F_MODE] : mode_q;
  assign pat_e   = wr_en ? wdata[F_PAT_LSB +: NPINS] : pat_q;
  assign mask_e  = wr_en ? wdata[F_MSK_LSB +: NPINS] : mask_q;
  assign fresh_e = fresh_q | wr_en;
  assign fire    = hit & en_e;
  assign over_w  = fire & ~fresh_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; sel_q <= '0; det_q <= '0; mode_q <= 1'b0;
      pat_q <= '0; mask_q <= '0; pol_q <= 1'b0; ovr_q <= 1'b0;
      fresh_q <= 1'b0; irq_q <= 1'b0; dma_q <= 1'b0;
    end else begin
      if (wr_en) begin
        en_q   <= wdata[F_EN];
        sel_q  <= wdata[F_SEL_LSB +: SELW];
        det_q  <= wdata[F_DET_LSB +: 2];
        mode_q <= wdata[F_MODE];
        pat_q  <= wdata[F_PAT_LSB +: NPINS];
        mask_q <= wdata[F_MSK_LSB +: NPINS];
        pol_q  <= wdata[F_POL];
      end
      if (over_w)                       ovr_q <= 1'b1;
      else if (wr_en && !wdata[F_OVR])  ovr_q <= 1'b0;
      if (fire)       fresh_q <= 1'b0;
      else if (wr_en) fresh_q <= 1'b1;
      irq_q <= over_w;
      dma_q <= over_w;
    end
  end

  assign src_sel = sel_q;
  assign det     = det_q;
  assign invert  = pol_q;
  assign irq     = irq_q;
  assign dma     = dma_q;

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[F_EN]                = en_q;
    ctrl_rd[F_SEL_LSB +: SELW]   = sel_q;
    ctrl_rd[F_DET_LSB +: 2]      = det_q;
    ctrl_rd[F_MODE]              = mode_q;
    ctrl_rd[F_PAT_LSB +: NPINS]  = pat_q;
    ctrl_rd[F_MSK_LSB +: NPINS]  = mask_q;
    ctrl_rd[F_OVR]               = ovr_q;
    ctrl_rd[F_POL]               = pol_q;
    ctrl_rd[F_ST_LSB +: NPINS]   = pins;
  end

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(fire));
  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ovr_q);
  // R11
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_q) |-> ($past(wr_en) && !$past(wdata[F_OVR])));
  // R14
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fire) |=> !irq_q);
  // R12
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |-> !fire);

endmodule

// File: rtl/evt_pin_driver.sv
module evt_pin_driver #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             toggle,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] pat,
  output logic [NPINS-1:0] pins
);
  logic [NPINS-1:0] pins_q;
  logic [NPINS-1:0] nxt_w;

  function automatic logic [NPINS-1:0] next_pins(logic tgl, logic [NPINS-1:0] cur,
                                                 logic [NPINS-1:0] m, logic [NPINS-1:0] p);
    if (tgl) return cur ^ (m & p);
    return (cur & ~m) | (m & p);
  endfunction

  assign nxt_w = next_pins(toggle, pins_q, mask, pat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pins_q <= '0;
    else if (fire) pins_q <= nxt_w;
  end

  assign pins = pins_q;

  // R7
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (((pins_q ^ $past(pins_q)) & ~$past(mask)) == '0));
  // R8
  direct_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !toggle) |=> (((pins_q ^ $past(pat)) & $past(mask)) == '0));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pins_q));

endmodule

// File: rtl/evt_pattern_out.sv
module evt_pattern_out
  import evt_pattern_pkg::*;
#(
  parameter int NPINS       = 4,
  parameter int NSRC        = 2,
  parameter int SELW        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  tmr_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic [NPINS-1:0] pins_o,
  output logic             irq_o,
  output logic             dma_sync_o
);
  logic             ctrl_wr_w, hit_w, fire_w, invert_w, mode_w;
  logic [SELW-1:0]  src_sel_w;
  logic [1:0]       det_w;
  logic [NPINS-1:0] mask_w, pat_w, pins_w;
  logic [31:0]      ctrl_rd_w;

  assign ctrl_wr_w = reg_we_i & ~reg_sel_i;

  evt_trigger #(.NSRC(NSRC), .SELW(SELW), .SYNC_STAGES(SYNC_STAGES)) trig_i (
    .clk(clk), .rst_n(rst_n), .tmr_raw(tmr_i), .src_sel(src_sel_w),
    .invert(invert_w), .det(det_w), .hit(hit_w));

  evt_ctrl_regs #(.NPINS(NPINS), .SELW(SELW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr_w), .wdata(reg_wdata_i),
    .hit(hit_w), .pins(pins_w), .fire(fire_w), .src_sel(src_sel_w),
    .det(det_w), .invert(invert_w), .mode_e(mode_w), .mask_e(mask_w),
    .pat_e(pat_w), .irq(irq_o), .dma(dma_sync_o), .ctrl_rd(ctrl_rd_w));

  evt_pin_driver #(.NPINS(NPINS)) pins_i (
    .clk(clk), .rst_n(rst_n), .fire(fire_w), .toggle(mode_w),
    .mask(mask_w), .pat(pat_w), .pins(pins_w));

  assign pins_o      = pins_w;
  assign reg_rdata_o = reg_sel_i ? ID_WORD : ctrl_rd_w;

endmodule

// File: tb/evt_pattern_out_tb.sv
module evt_pattern_out_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tmr = 2'b00;
  logic        we = 1'b0;
  logic        rsel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pins;
  logic        irq, dma;

  int errors = 0;
  int checks = 0;
  logic [3:0] exp_pins = 4'h0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  evt_pattern_out dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_i(tmr), .reg_we_i(we), .reg_sel_i(rsel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pins_o(pins), .irq_o(irq),
    .dma_sync_o(dma));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic en, input logic [3:0] sel,
      input logic [1:0] det, input logic mode, input logic [3:0] pat,
      input logic [3:0] mask, input logic ovr, input logic pol);
    return {14'd0, pol, ovr, mask, pat, mode, det, sel, en};
  endfunction

  task automatic wr(input logic s, input logic [31:0] d);
    rsel = s; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; rsel = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    rsel = s; #1; v = rdata; rsel = 1'b0; #1;
  endtask

  task automatic cfg(input logic [3:0] sel, input logic [1:0] det, input logic mode,
                     input logic [3:0] pat, input logic [3:0] mask, input logic pol);
    wr(1'b0, word(1'b0, sel, det, mode, pat, mask, 1'b0, pol));
    repeat (4) @(negedge clk);
    wr(1'b0, word(1'b1, sel, det, mode, pat, mask, 1'b0, pol));
  endtask

  task automatic wait3();
    repeat (3) @(negedge clk);
  endtask

  // expected pin update, restated bit by bit
  function automatic logic [3:0] model(input logic mode, input logic [3:0] cur,
                                       input logic [3:0] mask, input logic [3:0] pat);
    logic [3:0] r;
    for (int b = 0; b < 4; b++) begin
      if (!mask[b])  r[b] = cur[b];
      else if (mode) r[b] = pat[b] ? ~cur[b] : cur[b];
      else           r[b] = pat[b];
    end
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, rv);
    check("R1 control", rv, 32'h0);
    check("R1 pins", {28'd0, pins}, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    check("R1 dma", {31'd0, dma}, 32'h0);

    // R3 identification word, read-only
    rd(1'b1, rv);
    check("R3 id", rv, 32'h44D0_0101);
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, rv);
    check("R3 id after write", rv, 32'h44D0_0101);
    rd(1'b0, rv);
    check("R3 control after id write", rv, 32'h0);

    // R7 R8 R9: sweep mode x mask x pattern on both edges of line 0
    cfg(4'd0, 2'b11, 1'b0, 4'h0, 4'h0, 1'b0);
    for (int m = 0; m < 2; m++) begin
      for (int mk = 0; mk < 16; mk++) begin
        for (int pt = 0; pt < 16; pt++) begin
          wr(1'b0, word(1'b1, 4'd0, 2'b11, m[0], pt[3:0], mk[3:0], 1'b0, 1'b0));
          tmr[0] = ~tmr[0];
          wait3();
          exp_pins = model(m[0], exp_pins, mk[3:0], pt[3:0]);
          check(m[0] ? "R7 R9 toggle pins" : "R7 R8 direct pins", {28'd0, pins}, {28'd0, exp_pins});
          check("R10 no overrun when rewritten", {31'd0, irq}, 32'h0);
        end
      end
    end

    // R2 layout and read-only upper bits
    rd(1'b0, rv);
    check("R2 readback", rv, word(1'b1, 4'd0, 2'b11, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0) | {10'd0, exp_pins, 18'd0});
    wr(1'b0, 32'hFFFC_0000 | word(1'b1, 4'd0, 2'b11, 1'b1, 4'hA, 4'h5, 1'b0, 1'b0));
    rd(1'b0, rv);
    check("R2 upper bits ignored", rv, word(1'b1, 4'd0, 2'b11, 1'b1, 4'hA, 4'h5, 1'b0, 1'b0) | {10'd0, exp_pins, 18'd0});

    // R4 R5 R6: source x polarity x edge code, toggling all pins per event
    for (int si = 0; si < 4; si++) begin
      for (int pl = 0; pl < 2; pl++) begin
        for (int dt = 0; dt < 4; dt++) begin
          logic [3:0] sv;
          sv = (si < 2) ? si[3:0] : ((si == 2) ? 4'd2 : 4'd15);
          cfg(sv, dt[1:0], 1'b1, 4'hF, 4'hF, pl[0]);
          for (int st = 0; st < 4; st++) begin
            int idx;
            logic eo, en_l, fr;
            idx = st % 2;
            eo = tmr[idx] ^ pl[0];
            tmr[idx] = ~tmr[idx];
            en_l = tmr[idx] ^ pl[0];
            fr = (sv == 4'(idx)) &&
                 ((dt[0] && !eo && en_l) || (dt[1] && eo && !en_l));
            wait3();
            if (fr) exp_pins = ~exp_pins;
            check("R4 R5 R6 source edge polarity", {28'd0, pins}, {28'd0, exp_pins});
          end
        end
      end
    end

    // R13 latency, R10 overrun, R11 clear rules (line 0 rising only)
    begin
      logic [3:0] p5;
      p5 = ~exp_pins;
      cfg(4'd0, 2'b01, 1'b0, p5, 4'hF, 1'b0);
      tmr[0] = 1'b1;
      repeat (2) @(negedge clk);
      check("R13 not before third edge", {28'd0, pins}, {28'd0, exp_pins});
      @(negedge clk);
      exp_pins = p5;
      check("R13 at third edge", {28'd0, pins}, {28'd0, exp_pins});
      check("R10 first event no irq", {31'd0, irq}, 32'h0);
      tmr[0] = 1'b0;
      wait3();
      check("R5 falling ignored in rise mode", {28'd0, pins}, {28'd0, exp_pins});
      tmr[0] = 1'b1;
      wait3();
      check("R10 irq on overrun", {31'd0, irq}, 32'h1);
      check("R10 dma on overrun", {31'd0, dma}, 32'h1);
      rd(1'b0, rv);
      check("R10 overrun bit", {31'd0, rv[16]}, 32'h1);
      @(negedge clk);
      check("R10 irq single cycle", {31'd0, irq}, 32'h0);
      check("R10 dma single cycle", {31'd0, dma}, 32'h0);
      wr(1'b0, word(1'b1, 4'd0, 2'b01, 1'b0, p5, 4'hF, 1'b1, 1'b0));
      rd(1'b0, rv);
      check("R11 write 1 keeps overrun", {31'd0, rv[16]}, 32'h1);
      wr(1'b0, word(1'b1, 4'd0, 2'b01, 1'b0, p5, 4'hF, 1'b0, 1'b0));
      rd(1'b0, rv);
      check("R11 write 0 clears overrun", {31'd0, rv[16]}, 32'h0);
    end

    // R14 write in the event cycle
    cfg(4'd0, 2'b11, 1'b0, 4'h3, 4'hF, 1'b0);
    tmr[0] = ~tmr[0];
    wait3();
    exp_pins = 4'h3;
    check("R14 setup pins", {28'd0, pins}, {28'd0, exp_pins});
    tmr[0] = ~tmr[0];
    repeat (2) @(negedge clk);
    wr(1'b0, word(1'b1, 4'd0, 2'b11, 1'b0, 4'hC, 4'hF, 1'b0, 1'b0));
    exp_pins = 4'hC;
    check("R14 new pattern used", {28'd0, pins}, {28'd0, exp_pins});
    check("R14 no irq", {31'd0, irq}, 32'h0);
    check("R14 no dma", {31'd0, dma}, 32'h0);
    rd(1'b0, rv);
    check("R14 no overrun bit", {31'd0, rv[16]}, 32'h0);

    // R12 disabled: edges ignored, nothing pending afterwards
    cfg(4'd0, 2'b11, 1'b0, 4'hF, 4'hF, 1'b0);
    tmr[0] = ~tmr[0];
    wait3();
    exp_pins = 4'hF;
    check("R12 setup pins", {28'd0, pins}, {28'd0, exp_pins});
    wr(1'b0, word(1'b0, 4'd0, 2'b11, 1'b0, 4'h0, 4'hF, 1'b0, 1'b0));
    tmr[0] = ~tmr[0];
    wait3();
    repeat (2) @(negedge clk);
    check("R12 disabled pins hold", {28'd0, pins}, {28'd0, exp_pins});
    check("R12 disabled no irq", {31'd0, irq}, 32'h0);
    wr(1'b0, word(1'b1, 4'd0, 2'b11, 1'b0, 4'h0, 4'hF, 1'b0, 1'b0));
    repeat (4) @(negedge clk);
    check("R12 nothing pending", {28'd0, pins}, {28'd0, exp_pins});
    tmr[0] = ~tmr[0];
    wait3();
    exp_pins = 4'h0;
    check("R12 active again", {28'd0, pins}, {28'd0, exp_pins});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule